// File: doc/BRIEF.md
# SIMD Saturating Lane Narrowing Unit

This block squeezes two 128-bit vectors of integer lanes into a single 128-bit vector whose lanes are half as wide. The result holds twice as many lanes as each operand. Each source lane is clamped to the range of the narrow type before its upper half is dropped, so values that do not fit stick at a bound and do not wrap. The source lane width is 16, 32 or 64 bits, which gives 8, 16 or 32-bit result lanes.

The block has three clamping modes. Signed-to-signed reads lanes as two's complement and clamps them to the signed range of the narrow type. Signed-to-unsigned reads lanes as two's complement and clamps them to the range from zero to the unsigned maximum. Unsigned-to-unsigned reads lanes as plain magnitudes, so any lane with its sign bit set counts as very large and gives the unsigned maximum. The result is registered. A flag vector shows which output lanes were clamped.

Top module: `simd_narrow_sat`

## Requirements
- R1: `out_valid` goes high on the clock edge after an edge where `in_valid` is high, and is low after any edge where `in_valid` is low. Asserting `rst_n` low clears `out_valid` at once.
- R2: Narrowed lanes of `opa` fill output lanes 0..N-1 in source order, and narrowed lanes of `opb` fill output lanes N..2N-1. N is 128 divided by the source lane width. Lane k of a vector occupies bits [k*W+W-1 : k*W].
- R3: With `mode_sel`=00 (signed to signed), each lane is clamped to [-2^(H-1), 2^(H-1)-1], where H is half the source width. Examples: 16->8 maps 128 to 127 and -32768 to -128, and 64->32 maps 5000000000 to 2147483647.
- R4: With `mode_sel`=01 (signed to unsigned), each signed lane is clamped to [0, 2^H-1]. Negative lanes give 0, and 255 in a 16-bit lane stays 255.
- R5: With `mode_sel`=10 (unsigned to unsigned), each lane is read as unsigned and clamped to 2^H-1. Examples: a 16-bit lane holding -32 or 65535 gives 255, and a 64-bit lane holding -100000 gives 4294967295.
- R6: `width_sel` 00, 01 and 10 select 16, 32 and 64-bit source lanes, which give 8, 16 and 32-bit output lanes. Lanes already in range pass through unchanged.
- R7: Bit i of `out_sat` is high exactly when output lane i was clamped. Bits at and above 2N are zero.
- R8: `mode_sel`=11 or `width_sel`=11 is reserved. Such an input gives `out_data`=0 and `out_sat`=0 with `out_err`=1. Any other accepted input gives `out_err`=0.
- R9: While `in_valid` is low, `out_data`, `out_sat` and `out_err` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accept operands this cycle |
| opa | input | 128 | First operand; its lanes go to the low result lanes |
| opb | input | 128 | Second operand; its lanes go to the high result lanes |
| width_sel | input | 2 | Source lane width: 00=16, 01=32, 10=64, 11 reserved |
| mode_sel | input | 2 | Clamp mode: 00 s->s, 01 s->u, 10 u->u, 11 reserved |
| out_valid | output | 1 | Result valid |
| out_data | output | 128 | Packed narrowed result |
| out_sat | output | 16 | Per-output-lane clamp flags |
| out_err | output | 1 | Reserved select code was used |

## Verification
Every result (`out_data`, `out_sat`, `out_err` and `out_valid`) passes through exactly one register. The bench drives operands on a falling edge with `in_valid` high for one cycle and checks the outputs on the next falling edge, which is half a cycle after the capturing rising edge. On the falling edge after that, with `in_valid` low, it changes the operands and confirms that the outputs hold and `out_valid` has dropped. Directed cases cover the saturation examples in each mode. Random vectors, biased towards in-range and sign-boundary lanes, are compared against a bench model that clamps in wide signed arithmetic.

// File: rtl/simd_narrow_pkg.sv
package simd_narrow_pkg;

  typedef enum logic [1:0] {
    MODE_S2S = 2'b00,
    MODE_S2U = 2'b01,
    MODE_U2U = 2'b10,
    MODE_RSV = 2'b11
  } narrow_mode_e;

  typedef enum logic [1:0] {
    SRC_W16 = 2'b00,
    SRC_W32 = 2'b01,
    SRC_W64 = 2'b10,
    SRC_RSV = 2'b11
  } narrow_width_e;

  localparam int unsigned NUM_WIDTHS = 3;
  localparam int unsigned MIN_SRC_W  = 16;

endpackage

// File: rtl/narrow_lane_clamp.sv
module narrow_lane_clamp
  import simd_narrow_pkg::*;
#(
  parameter int unsigned IN_W = 16
) (
  input  logic [IN_W-1:0]   lane_in,
  input  narrow_mode_e      mode,
  output logic [IN_W/2-1:0] lane_out,
  output logic              clamped
);

  localparam int unsigned OUT_W = IN_W / 2;

  logic sign_bit;
  logic upper_zero;    // bits above the narrow width all zero
  logic upper_s_zero;  // bits from narrow sign upward all zero
  logic upper_s_ones;  // bits from narrow sign upward all one

  assign sign_bit     = lane_in[IN_W-1];
  assign upper_zero   = ~|lane_in[IN_W-1:OUT_W];
  assign upper_s_zero = ~|lane_in[IN_W-1:OUT_W-1];
  assign upper_s_ones = &lane_in[IN_W-1:OUT_W-1];

  always_comb begin
    lane_out = lane_in[OUT_W-1:0];
    clamped  = 1'b0;
    unique case (mode)
      MODE_S2S: begin
        if (!sign_bit && !upper_s_zero) begin
          lane_out = {1'b0, {(OUT_W-1){1'b1}}};
          clamped  = 1'b1;
        end else if (sign_bit && !upper_s_ones) begin
          lane_out = {1'b1, {(OUT_W-1){1'b0}}};
          clamped  = 1'b1;
        end
      end
      MODE_S2U: begin
        if (sign_bit) begin
          lane_out = '0;
          clamped  = 1'b1;
        end else if (!upper_zero) begin
          lane_out = '1;
          clamped  = 1'b1;
        end
      end
      MODE_U2U: begin
        if (!upper_zero) begin
          lane_out = '1;
          clamped  = 1'b1;
        end
      end
      default: begin
        lane_out = '0;
        clamped  = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/narrow_pack.sv
module narrow_pack
  import simd_narrow_pkg::*;
#(
  parameter int unsigned VEC_W = 128,
  parameter int unsigned IN_W  = 16
) (
  input  logic [VEC_W-1:0]   opa,
  input  logic [VEC_W-1:0]   opb,
  input  narrow_mode_e       mode,
  output logic [VEC_W-1:0]   data,
  output logic [VEC_W/8-1:0] sat
);

  localparam int unsigned OUT_W   = IN_W / 2;
  localparam int unsigned SRC_N   = VEC_W / IN_W;
  localparam int unsigned DST_N   = 2 * SRC_N;
  localparam int unsigned SAT_W   = VEC_W / 8;

  for (genvar g = 0; g < DST_N; g++) begin : g_lane
    logic [IN_W-1:0] src;
    if (g < SRC_N) begin : g_from_a
      assign src = opa[g*IN_W +: IN_W];
    end else begin : g_from_b
      assign src = opb[(g-SRC_N)*IN_W +: IN_W];
    end

    narrow_lane_clamp #(.IN_W(IN_W)) clamp_i (
      .lane_in  (src),
      .mode     (mode),
      .lane_out (data[g*OUT_W +: OUT_W]),
      .clamped  (sat[g])
    );
  end

  if (DST_N < SAT_W) begin : g_sat_pad
    assign sat[SAT_W-1:DST_N] = '0;
  end

endmodule

// File: rtl/simd_narrow_sat.sv
module simd_narrow_sat
  import simd_narrow_pkg::*;
#(
  parameter int unsigned VEC_W = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [VEC_W-1:0]   opa,
  input  logic [VEC_W-1:0]   opb,
  input  logic [1:0]         width_sel,
  input  logic [1:0]         mode_sel,
  output logic               out_valid,
  output logic [VEC_W-1:0]   out_data,
  output logic [VEC_W/8-1:0] out_sat,
  output logic               out_err
);

  localparam int unsigned SAT_W = VEC_W / 8;

  narrow_mode_e  mode;
  narrow_width_e width;
  logic          reserved;

  assign mode     = narrow_mode_e'(mode_sel);
  assign width    = narrow_width_e'(width_sel);
  assign reserved = (mode == MODE_RSV) || (width == SRC_RSV);

  logic [VEC_W-1:0] cand_data [NUM_WIDTHS];
  logic [SAT_W-1:0] cand_sat  [NUM_WIDTHS];

  for (genvar k = 0; k < NUM_WIDTHS; k++) begin : g_width
    narrow_pack #(
      .VEC_W (VEC_W),
      .IN_W  (MIN_SRC_W << k)
    ) pack_i (
      .opa  (opa),
      .opb  (opb),
      .mode (mode),
      .data (cand_data[k]),
      .sat  (cand_sat[k])
    );
  end

  // next-state
  logic             valid_d;
  logic [VEC_W-1:0] data_d;
  logic [SAT_W-1:0] sat_d;
  logic             err_d;
  logic             load_en;

  assign load_en = in_valid;

  always_comb begin
    valid_d = in_valid;
    data_d  = out_data;
    sat_d   = out_sat;
    err_d   = out_err;
    if (load_en) begin
      if (reserved) begin
        data_d = '0;
        sat_d  = '0;
        err_d  = 1'b1;
      end else begin
        data_d = cand_data[width_sel];
        sat_d  = cand_sat[width_sel];
        err_d  = 1'b0;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sat   <= '0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= valid_d;
      if (load_en) begin
        out_data <= data_d;
        out_sat  <= sat_d;
        out_err  <= err_d;
      end
    end
  end

endmodule

// File: rtl/simd_narrow_sat_chk.sv
module simd_narrow_sat_chk #(
  parameter int unsigned VEC_W = 128
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [VEC_W-1:0]   opa,
  input logic [VEC_W-1:0]   opb,
  input logic [1:0]         width_sel,
  input logic [1:0]         mode_sel,
  input logic               out_valid,
  input logic [VEC_W-1:0]   out_data,
  input logic [VEC_W/8-1:0] out_sat,
  input logic               out_err
);

  localparam int unsigned SAT_W  = VEC_W / 8;
  localparam int unsigned LN_W32 = 2 * VEC_W / 32;
  localparam int unsigned LN_W64 = 2 * VEC_W / 64;

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_valid_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_data) && $stable(out_sat) && $stable(out_err)));

  assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (mode_sel == 2'b11 || width_sel == 2'b11))
      |=> (out_err && out_data == '0 && out_sat == '0));

  assert_err_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_sel != 2'b11 && width_sel != 2'b11) |=> !out_err);

  assert_sat_unused32_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && width_sel == 2'b01) |=> (out_sat[SAT_W-1:LN_W32] == '0));

  assert_sat_unused64_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && width_sel == 2'b10) |=> (out_sat[SAT_W-1:LN_W64] == '0));

  assert_u2u_max_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_sel == 2'b10 && width_sel == 2'b00 && (|opa[15:8]))
      |=> (out_data[7:0] == 8'hFF && out_sat[0]));

  assert_s2u_neg_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_sel == 2'b01 && width_sel == 2'b00 && opb[15])
      |=> (out_data[8*(VEC_W/16) +: 8] == 8'h00));

endmodule

bind simd_narrow_sat simd_narrow_sat_chk #(.VEC_W(VEC_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .opa       (opa),
  .opb       (opb),
  .width_sel (width_sel),
  .mode_sel  (mode_sel),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_sat   (out_sat),
  .out_err   (out_err)
);

// File: tb/simd_narrow_sat_tb_top.sv
module simd_narrow_sat_tb_top;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [127:0] opa;
  logic [127:0] opb;
  logic [1:0]   width_sel;
  logic [1:0]   mode_sel;
  logic         out_valid;
  logic [127:0] out_data;
  logic [15:0]  out_sat;
  logic         out_err;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  simd_narrow_sat dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .opa       (opa),
    .opb       (opb),
    .width_sel (width_sel),
    .mode_sel  (mode_sel),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_sat   (out_sat),
    .out_err   (out_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bench model: clamp in wide signed arithmetic
  task automatic model(input logic [127:0] a, input logic [127:0] b,
                       input logic [1:0] w, input logic [1:0] m,
                       output logic [127:0] d, output logic [15:0] s, output logic e);
    int iw, ow, n;
    logic [63:0] x, mask, omask, r;
    logic signed [65:0] v, lo, hi;
    d = '0; s = '0; e = 1'b0;
    if (w == 2'b11 || m == 2'b11) begin
      e = 1'b1;
      return;
    end
    iw = 16 << w;
    ow = iw / 2;
    n  = 128 / iw;
    mask  = (iw == 64) ? '1 : ((64'd1 << iw) - 64'd1);
    omask = (64'd1 << ow) - 64'd1;
    for (int i = 0; i < 2 * n; i++) begin
      x = (i < n) ? 64'(a >> (i * iw)) : 64'(b >> ((i - n) * iw));
      x = x & mask;
      if (m != 2'b10 && x[iw-1])
        v = $signed({2'b00, x}) - (66'sd1 <<< iw);
      else
        v = $signed({2'b00, x});
      if (m == 2'b00) begin
        lo = -(66'sd1 <<< (ow - 1));
        hi = (66'sd1 <<< (ow - 1)) - 66'sd1;
      end else begin
        lo = 66'sd0;
        hi = (66'sd1 <<< ow) - 66'sd1;
      end
      if (v < lo) begin v = lo; s[i] = 1'b1; end
      else if (v > hi) begin v = hi; s[i] = 1'b1; end
      r = v[63:0] & omask;
      d = d | ({64'd0, r} << (i * ow));
    end
  endtask

  function automatic logic [127:0] pk16(input int v[8]);
    logic [127:0] t = '0;
    for (int i = 0; i < 8; i++) t[i*16 +: 16] = 16'(v[i]);
    return t;
  endfunction

  function automatic logic [127:0] pk32(input int v[4]);
    logic [127:0] t = '0;
    for (int i = 0; i < 4; i++) t[i*32 +: 32] = 32'(v[i]);
    return t;
  endfunction

  // drive one vector, check result, then check hold with changed inputs
  task automatic run_vec(input string req, input logic [127:0] a, input logic [127:0] b,
                         input logic [1:0] w, input logic [1:0] m);
    logic [127:0] ed;
    logic [15:0]  es;
    logic         ee;
    logic [127:0] held_d;
    model(a, b, w, m, ed, es, ee);
    @(negedge clk);
    opa = a; opb = b; width_sel = w; mode_sel = m; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " R1 valid"}, {127'd0, out_valid}, 128'd1);
    check({req, " data"}, out_data, ed);
    check({req, " R7 sat"}, {112'd0, out_sat}, {112'd0, es});
    check({req, " R8 err"}, {127'd0, out_err}, {127'd0, ee});
    held_d = out_data;
    opa = ~a; opb = ~b; mode_sel = m ^ 2'b01;
    @(negedge clk);
    check({req, " R9 hold"}, out_data, held_d);
    check({req, " R1 drop"}, {127'd0, out_valid}, 128'd0);
  endtask

  function automatic logic [127:0] rnd_vec(input int kind);
    logic [127:0] t;
    for (int i = 0; i < 4; i++) t[i*32 +: 32] = $urandom;
    if (kind == 1) begin
      for (int i = 0; i < 16; i++) t[i*8 +: 8] = (i % 2) ? {8{t[i*8-1]}} : t[i*8 +: 8];
    end else if (kind == 2) begin
      for (int i = 0; i < 16; i++) if (i % 2) t[i*8 +: 8] = 8'h00;
    end
    return t;
  endfunction

  initial begin
    logic [127:0] a, b;
    void'($urandom(32'h5EED_0717));
    rst_n = 1'b0; in_valid = 1'b0; opa = '0; opb = '0; width_sel = '0; mode_sel = '0;
    repeat (3) @(negedge clk);
    check("R1 reset valid", {127'd0, out_valid}, 128'd0);
    check("R1 reset err", {127'd0, out_err}, 128'd0);
    rst_n = 1'b1;

    // 16->8 directed, all three modes (R3 R4 R5 R2 R6)
    a = pk16('{1, 127, 128, 15, 32767, -32, 48, 0});
    b = pk16('{8, 255, -100, 100, -32768, 73, 80, 42});
    run_vec("R3 s2s w16", a, b, 2'b00, 2'b00);
    check("R3 128->127", {120'd0, out_data[23:16]}, 128'd127);
    check("R3 -32768->-128", {120'd0, out_data[103:96]}, 128'h80);
    run_vec("R4 s2u w16", a, b, 2'b00, 2'b01);
    check("R4 255 stays", {120'd0, out_data[79:72]}, 128'd255);
    check("R4 -100->0", {120'd0, out_data[87:80]}, 128'd0);
    run_vec("R5 u2u w16", a, b, 2'b00, 2'b10);
    check("R5 -32->255", {120'd0, out_data[47:40]}, 128'd255);

    // 32->16 directed
    a = pk32('{32767, 1048575, -70000, -5});
    b = pk32('{268435455, 73, 268435455, 42});
    run_vec("R3 s2s w32", a, b, 2'b01, 2'b00);
    check("R3 R2 w32 lanes", out_data,
          {16'd42, 16'h7FFF, 16'd73, 16'h7FFF, 16'hFFFB, 16'h8000, 16'h7FFF, 16'h7FFF});

    // 64->32 directed
    a = {-64'sd100000, 64'd65535};
    b = {64'd73, 64'd5000000000};
    run_vec("R3 s2s w64", a, b, 2'b10, 2'b00);
    check("R3 R2 w64 lanes", out_data, {32'd73, 32'h7FFFFFFF, 32'hFFFE7960, 32'd65535});
    run_vec("R4 s2u w64", a, b, 2'b10, 2'b01);
    check("R4 w64 lanes", out_data, {32'd73, 32'hFFFFFFFF, 32'd0, 32'd65535});
    run_vec("R5 u2u w64", a, b, 2'b10, 2'b10);
    check("R5 w64 lanes", out_data, {32'd73, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'd65535});

    // R6 in-range pass-through, R2 ordering
    a = pk16('{1, 2, 3, 4, 5, 6, 7, 8});
    b = pk16('{9, 10, 11, 12, 13, 14, 15, 16});
    run_vec("R6 R2 pass w16", a, b, 2'b00, 2'b10);
    check("R6 R2 order", out_data, 128'h100F0E0D0C0B0A090807060504030201);

    // R8 reserved codes
    run_vec("R8 rsv mode", a, b, 2'b00, 2'b11);
    run_vec("R8 rsv width", a, b, 2'b11, 2'b00);

    // random
    for (int t = 0; t < 400; t++) begin
      logic [1:0] w, m;
      w = 2'($urandom % 3);
      m = 2'($urandom % 3);
      if ($urandom % 16 == 0) w = 2'b11;
      if ($urandom % 16 == 0) m = 2'b11;
      run_vec("R2 R3 R4 R5 R6 rand", rnd_vec($urandom % 3), rnd_vec($urandom % 3), w, m);
    end

    // R1 asynchronous reset clears valid
    @(negedge clk);
    opa = a; opb = b; width_sel = 2'b00; mode_sel = 2'b00; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b1;
    rst_n = 1'b0;
    #1;
    check("R1 async reset", {127'd0, out_valid}, 128'd0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule